// File: doc/BRIEF.md
# PHY Test Port Register Write Sequencer

This block writes one internal configuration register of a D-PHY through its bit-level test port. A single start strobe arrives with a 12-bit register address, an 8-bit data byte and a step length. The block then plays out a fixed waveform on three test-port signals: a test enable, a test clock and an 8-bit test data bus. The waveform first sends a zero code byte and the upper address bits, then the lower address byte, then the data byte.

The PHY latches code bytes on falling test-clock edges while the enable is high. It latches the upper-address byte and the data byte on rising edges while the enable is low. Every step of the waveform is held for a programmable number of system clocks, which gives setup and hold margin around each test-clock edge.

A busy output covers the whole write. A one-cycle done pulse marks the point where the port has gone quiet again.

Top module: `phy_tport_writer`

## Requirements
- R1: After reset, and whenever `busy` is low, `testEn`, `testClk` and `testDin` are all 0. `busy` and `done` are 0 after reset.
- R2: After an accepted start, the port plays 16 steps in order. Each step is listed as (enable, clock, data), where Z = 0x00, H = {4'b0, address[11:8]}, L = address[7:0] and D = the data byte: (1,0,Z) (1,1,Z) (1,1,Z) (1,0,Z) (0,0,Z) (0,0,H) (0,1,H) (0,0,H) (1,0,H) (1,1,H) (1,1,L) (1,0,L) (0,0,L) (0,0,D) (0,1,D) (0,0,D).
- R3: Each step lasts exactly N system clocks, where N is the step length sampled at start. A step length of 0 is treated as 1.
- R4: The falling test-clock edges that occur with the enable high carry, in order, 0x00 and then address[7:0]. No other falling edge occurs with the enable high.
- R5: The rising test-clock edges that occur with the enable low carry, in order, {4'b0, address[11:8]} and then the data byte. No other rising edge occurs with the enable low.
- R6: `testEn` changes only while `testClk` is low, both in the cycle before the change and in the cycle of the change.
- R7: `busy` rises on the clock edge that accepts the start. The first step appears on the port one cycle later. Step k (counting from 0) is visible for the N cycles starting k·N+1 cycles after acceptance. `done` is a single-cycle pulse 16·N+1 cycles after acceptance. On that same edge `busy` falls and the port returns to all zero.
- R8: A start strobe sampled while `busy` is high is ignored. This includes the final cycle before `done`.
- R9: Address, data and step length are captured when the start is accepted. Later changes to these inputs do not affect the write in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; accepted only while idle |
| addrIn | input | 12 | PHY test register address |
| dataIn | input | 8 | Byte to write |
| stepCycles | input | 8 | System clocks per waveform step (0 acts as 1) |
| busy | output | 1 | High from accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| testEn | output | 1 | Test enable to the PHY |
| testClk | output | 1 | Test clock to the PHY |
| testDin | output | 8 | Test data to the PHY |

## Verification
The bench compares the port against the step table in every cycle of each write. It also decodes the waveform the way the PHY would: it collects the values present at falling edges with the enable high and at rising edges with the enable low. This catches swapped address halves, a data byte latched on the wrong edge, or steps placed in the wrong order.

Step lengths of 0, 1 and 3 are exercised. A design that loads the length as given would stall for a length of 0, and an off-by-one in the divider would shift every later sample.

Starts are injected mid-write, and also in the final cycle before done. A design with a leaky start guard would restart or would chain a second write. The inputs are also changed right after acceptance, which exposes a design that fails to capture them.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;

  localparam int NUM_STEPS = 16;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  // Source of the byte placed on the test data bus in a step
  typedef enum logic [1:0] {
    DIN_ZERO = 2'd0,
    DIN_AHI  = 2'd1,
    DIN_ALO  = 2'd2,
    DIN_DATA = 2'd3
  } dinSel_e;

  // Level pattern of one waveform step
  typedef struct packed {
    logic    en;
    logic    tclk;
    dinSel_e dinSel;
  } stepPat_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    drive;
    logic    en;
    logic    tclk;
    dinSel_e dinSel;
    logic    finish;
  } seqCmd_t;

  // Fixed waveform: code-high preamble, high address, low address, data
  function automatic stepPat_t stepPattern(input logic [STEP_W-1:0] s);
    stepPat_t p;
    case (s)
      4'd0:    p = '{en: 1'b1, tclk: 1'b0, dinSel: DIN_ZERO};
      4'd1:    p = '{en: 1'b1, tclk: 1'b1, dinSel: DIN_ZERO};
      4'd2:    p = '{en: 1'b1, tclk: 1'b1, dinSel: DIN_ZERO};
      4'd3:    p = '{en: 1'b1, tclk: 1'b0, dinSel: DIN_ZERO};
      4'd4:    p = '{en: 1'b0, tclk: 1'b0, dinSel: DIN_ZERO};
      4'd5:    p = '{en: 1'b0, tclk: 1'b0, dinSel: DIN_AHI};
      4'd6:    p = '{en: 1'b0, tclk: 1'b1, dinSel: DIN_AHI};
      4'd7:    p = '{en: 1'b0, tclk: 1'b0, dinSel: DIN_AHI};
      4'd8:    p = '{en: 1'b1, tclk: 1'b0, dinSel: DIN_AHI};
      4'd9:    p = '{en: 1'b1, tclk: 1'b1, dinSel: DIN_AHI};
      4'd10:   p = '{en: 1'b1, tclk: 1'b1, dinSel: DIN_ALO};
      4'd11:   p = '{en: 1'b1, tclk: 1'b0, dinSel: DIN_ALO};
      4'd12:   p = '{en: 1'b0, tclk: 1'b0, dinSel: DIN_ALO};
      4'd13:   p = '{en: 1'b0, tclk: 1'b0, dinSel: DIN_DATA};
      4'd14:   p = '{en: 1'b0, tclk: 1'b1, dinSel: DIN_DATA};
      default: p = '{en: 1'b0, tclk: 1'b0, dinSel: DIN_DATA};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/phy_tport_ctrl.sv
module phy_tport_ctrl
  import phy_tport_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] stepCycles,
  output logic             busy,
  output seqCmd_t          cmd
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } ctrlState_e;

  ctrlState_e        state;
  logic [STEP_W-1:0] step;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  divLast;
  logic              accept;
  logic              stepEnd;
  stepPat_t          pat;

  assign accept  = start && (state == ST_IDLE);
  assign stepEnd = (cnt == divLast);
  assign pat     = stepPattern(step);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      step    <= '0;
      cnt     <= '0;
      divLast <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RUN;
            step    <= '0;
            cnt     <= '0;
            divLast <= (stepCycles == '0) ? '0 : stepCycles - 1'b1;
          end
        end
        ST_RUN: begin
          if (stepEnd) begin
            cnt <= '0;
            if (step == LAST_STEP) begin
              state <= ST_WRAP;
            end else begin
              step <= step + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.load   = accept;
    cmd.drive  = (state == ST_RUN);
    cmd.en     = pat.en;
    cmd.tclk   = pat.tclk;
    cmd.dinSel = pat.dinSel;
    cmd.finish = (state == ST_WRAP);
  end

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !stepEnd) |=> $stable(step));

  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start) |=> (state != ST_IDLE) && !(step == '0 && cnt == '0));

endmodule

// File: rtl/phy_tport_dp.sv
module phy_tport_dp
  import phy_tport_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DIN_W-1:0]  dataIn,
  output logic              testEn,
  output logic              testClk,
  output logic [DIN_W-1:0]  testDin,
  output logic              done
);

  localparam int HI_W = ADDR_W - DIN_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DIN_W-1:0]  dataQ;
  logic [DIN_W-1:0]  dinNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (cmd.load) begin
      addrQ <= addrIn;
      dataQ <= dataIn;
    end
  end

  always_comb begin
    case (cmd.dinSel)
      DIN_AHI:  dinNext = DIN_W'(addrQ[ADDR_W-1 -: HI_W]);
      DIN_ALO:  dinNext = addrQ[DIN_W-1:0];
      DIN_DATA: dinNext = dataQ;
      default:  dinNext = '0;
    endcase
  end

  // Registered port so the PHY never sees decode glitches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      testEn  <= 1'b0;
      testClk <= 1'b0;
      testDin <= '0;
      done    <= 1'b0;
    end else begin
      testEn  <= cmd.drive && cmd.en;
      testClk <= cmd.drive && cmd.tclk;
      testDin <= cmd.drive ? dinNext : '0;
      done    <= cmd.finish;
    end
  end

  // R6
  en_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(testEn) |-> !testClk && !$past(testClk));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/phy_tport_writer.sv
module phy_tport_writer
  import phy_tport_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIN_W  = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DIN_W-1:0]  dataIn,
  input  logic [DIV_W-1:0]  stepCycles,
  output logic              busy,
  output logic              done,
  output logic              testEn,
  output logic              testClk,
  output logic [DIN_W-1:0]  testDin
);

  seqCmd_t cmd;

  phy_tport_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .stepCycles (stepCycles),
    .busy       (busy),
    .cmd        (cmd)
  );

  phy_tport_dp #(.ADDR_W(ADDR_W), .DIN_W(DIN_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .testEn  (testEn),
    .testClk (testClk),
    .testDin (testDin),
    .done    (done)
  );

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !testEn && !testClk && (testDin == '0));

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

endmodule

// File: tb/tb_phy_tport_writer.sv
module tb_phy_tport_writer;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  stepCycles = '0;
  logic        busy, done, testEn, testClk;
  logic [7:0]  testDin;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_tport_writer dut (
    .clk(clk), .rstN(rstN), .start(start), .addrIn(addrIn), .dataIn(dataIn),
    .stepCycles(stepCycles), .busy(busy), .done(done), .testEn(testEn),
    .testClk(testClk), .testDin(testDin)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Step table from R2: returns {en, clk, din}
  function automatic logic [9:0] expStep(input int s, input logic [11:0] a,
                                         input logic [7:0] d);
    logic [7:0] z, h, l;
    z = 8'h00; h = {4'b0, a[11:8]}; l = a[7:0];
    case (s)
      0: return {2'b10, z};  1: return {2'b11, z};  2: return {2'b11, z};
      3: return {2'b10, z};  4: return {2'b00, z};  5: return {2'b00, h};
      6: return {2'b01, h};  7: return {2'b00, h};  8: return {2'b10, h};
      9: return {2'b11, h}; 10: return {2'b11, l}; 11: return {2'b10, l};
     12: return {2'b00, l}; 13: return {2'b00, d}; 14: return {2'b01, d};
      default: return {2'b00, d};
    endcase
  endfunction

  task automatic checkIdle(input string req);
    check(!testEn && !testClk && testDin == 8'h00, req,
          {22'b0, testEn, testClk, testDin}, 32'h0);
    check(!busy && !done, req, {30'b0, busy, done}, 32'h0);
  endtask

  // One write; intrude injects a start mid-run, lateStart one in the last busy cycle
  task automatic runSeq(input logic [11:0] a, input logic [7:0] d, input int k,
                        input bit intrude, input bit lateStart);
    int kEff;
    int total;
    logic pClk;
    logic [7:0] falls[$];
    logic [7:0] rises[$];
    logic [9:0] expv;
    kEff  = (k == 0) ? 1 : k;
    total = 16 * kEff;
    pClk  = 1'b0;
    @(negedge clk);
    start = 1'b1; addrIn = a; dataIn = d; stepCycles = 8'(k);
    @(posedge clk);
    for (int n = 0; n <= total + 1; n++) begin
      @(negedge clk);
      if (n == 0) begin
        // R9: scramble inputs right after acceptance
        start = 1'b0; addrIn = ~a; dataIn = ~d; stepCycles = 8'd1;
      end
      if (intrude && n == 4) start = 1'b1;
      if (intrude && n == 5) start = 1'b0;
      if (lateStart && n == total) start = 1'b1;
      if (n == total + 1) start = 1'b0;
      if (n == 0 || n == total + 1) expv = 10'h0;
      else expv = expStep((n - 1) / kEff, a, d);
      // R2 R3 R7 waveform position
      check({testEn, testClk, testDin} == expv, "R2/R3 step", {testEn, testClk, testDin}, expv);
      // R7 busy and done timing
      check(busy == (n <= total) && done == (n == total + 1), "R7 busy/done",
            {busy, done}, {n <= total, n == total + 1});
      if (pClk && !testClk && testEn) falls.push_back(testDin);
      if (!pClk && testClk && !testEn) rises.push_back(testDin);
      pClk = testClk;
    end
    // R4 code bytes on falling edges with enable high
    check(falls.size() == 2, "R4 count", falls.size(), 2);
    if (falls.size() == 2) begin
      check(falls[0] == 8'h00, "R4 first", falls[0], 0);
      check(falls[1] == a[7:0], "R4 low addr", falls[1], a[7:0]);
    end
    // R5 bytes on rising edges with enable low
    check(rises.size() == 2, "R5 count", rises.size(), 2);
    if (rises.size() == 2) begin
      check(rises[0] == {4'b0, a[11:8]}, "R5 high addr", rises[0], {4'b0, a[11:8]});
      check(rises[1] == d, "R5 data", rises[1], d);
    end
    if (lateStart) begin
      // R8: start in final busy cycle must not begin a new write
      @(negedge clk);
      check(!busy, "R8 late start", busy, 0);
      checkIdle("R1 after late start");
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkIdle("R1 reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1 idle");
  endtask

  initial begin
    testReset();
    runSeq(12'h0E4, 8'h11, 1, 1'b0, 1'b0);
    runSeq(12'hFFF, 8'hA5, 3, 1'b1, 1'b0);   // R8 mid-run start, R9
    runSeq(12'h800, 8'h00, 0, 1'b0, 1'b1);   // R3 zero length, R8 late start
    runSeq(12'h008, 8'h38, 2, 1'b1, 1'b0);
    runSeq(12'h5A3, 8'hC3, 1, 1'b0, 1'b0);   // back to back
    @(negedge clk);
    checkIdle("R1 end");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule